// File: doc/BRIEF.md
# Scan Test Vector Sequencer

This block runs a stored set of combinational test vectors through a full-scan circuit. For each vector it shifts a present state into every scan chain of the circuit. It then spends one clock in normal mode, in which it drives the primary inputs and checks the primary outputs. The captured next state leaves the chains during the shifts that load the following vector. After the last capture, one extra shift pass unloads the final response. Every unloaded bit and every primary-output bit is compared against a stored expected value under a per-bit care mask. A sticky fail flag keeps the index of the lowest-numbered failing vector.

Vectors are written into an internal memory while the sequencer is idle. A one-cycle start pulse begins a run. The sequencer drives the circuit's test-control line, its scan-in pins and its primary inputs from registers. It reads the scan-out pins and the primary outputs directly. All chains shift together, and the count of shifts equals the longest chain length. A shorter chain receives leading filler bits, which fall out of its far end, so every chain finishes loading on the same clock.

Top module: `scanvec_sequencer`

## Requirements
- R1: On reset, busy, done and fail are 0, fail_vec is 0, test_ctrl is 1 (normal mode), and scan_in and pi_out are all 0.
- R2: Each vector word has the following layout, where S is SHIFT_LEN and C is NCHAIN:
  - load bits at [C*S-1:0], with chain c at [c*S +: S];
  - expected unload bits at [2CS-1:CS];
  - unload care bits at [3CS-1:2CS];
  - primary-input values at [3CS +: NPI];
  - expected primary outputs next, then the primary-output care bits.
  A write takes effect when wr_en is high while the sequencer is idle and start is low. A write at any other time is ignored. A write made in the cycle before a start is used by that run.
- R3: An accepted start gives one setup cycle. Each vector then gets exactly SHIFT_LEN shift cycles with test_ctrl = 0, followed by exactly one capture cycle with test_ctrl = 1. A final pass of SHIFT_LEN shift cycles follows the last capture. busy is high for 1 + (NVEC+1)·SHIFT_LEN + NVEC cycles. A start while busy is ignored, and test_ctrl is 1 whenever the block is idle.
- R4: During a load, bit SHIFT_LEN-1 of each chain's load field is driven on the first shift cycle and bit 0 on the last. A chain of length L therefore ends holding the low L bits of its field, and the upper bits act as leading filler.
- R5: pi_out carries the vector's primary-input field during its capture cycle and is 0 in every other cycle. scan_in is 0 outside shift cycles and during the final unload pass.
- R6: Bit j of a vector's expected unload field for chain c is compared with scan_out[c] sampled on shift cycle j (counting from 0) of the shift pass that follows that vector's capture. A mismatch counts only where the matching care bit is 1.
- R7: During a vector's capture cycle, po_in is compared with the expected primary-output field under its care bits.
- R8: The first mismatch sets fail and records that vector's index in fail_vec. Both then hold until the next accepted start clears them. done rises after the last unload shift and stays high until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a run (accepted only while idle) |
| wr_en | input | 1 | Vector memory write strobe |
| wr_addr | input | IW | Vector index to write |
| wr_data | input | W | Vector word, layout as in R2 |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run completed |
| fail | output | 1 | Sticky mismatch flag |
| fail_vec | output | IW | Index of the first failing vector |
| test_ctrl | output | 1 | 0 = shift mode, 1 = normal (capture) mode |
| scan_in | output | NCHAIN | Serial data into each chain |
| scan_out | input | NCHAIN | Serial data from each chain |
| pi_out | output | NPI | Primary inputs of the circuit under test |
| po_in | input | NPO | Primary outputs of the circuit under test |

## Verification
The bench places the sequencer against a behavioural circuit that has one full-length chain and one half-length chain. A design that shifted the load fields in the wrong order, or that did not pad the short chain, would unload responses that disagree with the stored expectations and would raise fail on clean data. The bench also plants errors at specific points:
- a corrupted unload bit in a middle vector;
- an earlier primary-output error;
- an error hidden by a cleared care bit;
- an error that only the final unload pass can see.

A design with the compare misaligned by a shift, the wrong vector index attached, the mask ignored, or no tail pass would then report the wrong verdict or index. A start and a memory write are also issued in the middle of a run; a design that honoured either would lengthen the run or damage the next run's data.

// File: rtl/scanvec_pkg.sv
package scanvec_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_FETCH = 2'd1,
    PH_SHIFT = 2'd2,
    PH_CAPT  = 2'd3
  } phase_e;

  function automatic int idx_bits(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/scanvec_store.sv
module scanvec_store #(
  parameter int W     = 31,
  parameter int DEPTH = 4,
  parameter int AW    = 2
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata_q
);

  logic [W-1:0] mem [DEPTH];

  // single write port, registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_q <= mem[raddr];
  end

endmodule

// File: rtl/scanvec_ctrl.sv
module scanvec_ctrl
  import scanvec_pkg::*;
#(
  parameter int SHIFT_LEN = 4,
  parameter int NVEC      = 4,
  parameter int CW        = 2,
  parameter int IW        = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output phase_e        phase_q,
  output phase_e        nxt_phase,
  output logic [CW-1:0] cnt_q,
  output logic          first_q,
  output logic [IW-1:0] cur_idx_q,
  output logic [IW-1:0] prev_idx_q,
  output logic [IW-1:0] ptr_q,
  output logic          enter_new,
  output logic          enter_tail,
  output logic          shift_more,
  output logic          accept,
  output logic          busy_q,
  output logic          done_q,
  output logic          tc_q
);

  localparam logic [CW-1:0] CNT_LAST = CW'(SHIFT_LEN - 1);
  localparam logic [IW-1:0] VEC_LAST = IW'(NVEC - 1);

  logic tail_q;
  logic last_shift;
  logic last_vec;

  assign last_shift = (cnt_q == CNT_LAST);
  assign last_vec   = (cur_idx_q == VEC_LAST);
  assign shift_more = (phase_q == PH_SHIFT) && !last_shift;
  assign accept     = (phase_q == PH_IDLE) && start;

  always_comb begin
    nxt_phase  = phase_q;
    enter_new  = 1'b0;
    enter_tail = 1'b0;
    unique case (phase_q)
      PH_IDLE:  if (start) nxt_phase = PH_FETCH;
      PH_FETCH: begin
        nxt_phase = PH_SHIFT;
        enter_new = 1'b1;
      end
      PH_SHIFT: if (last_shift) nxt_phase = tail_q ? PH_IDLE : PH_CAPT;
      PH_CAPT: begin
        nxt_phase = PH_SHIFT;
        if (last_vec) enter_tail = 1'b1;
        else          enter_new  = 1'b1;
      end
      default:  nxt_phase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_IDLE;
      cnt_q      <= '0;
      first_q    <= 1'b0;
      tail_q     <= 1'b0;
      cur_idx_q  <= '0;
      prev_idx_q <= '0;
      ptr_q      <= '0;
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      tc_q       <= 1'b1;
    end else begin
      phase_q <= nxt_phase;
      busy_q  <= (nxt_phase != PH_IDLE);
      tc_q    <= (nxt_phase != PH_SHIFT);
      cnt_q   <= shift_more ? cnt_q + 1'b1 : '0;

      if (phase_q == PH_FETCH) begin
        first_q   <= 1'b1;
        tail_q    <= 1'b0;
        cur_idx_q <= '0;
      end
      if (phase_q == PH_CAPT) begin
        first_q    <= 1'b0;
        prev_idx_q <= cur_idx_q;
        if (!last_vec) cur_idx_q <= cur_idx_q + 1'b1;
      end
      if (enter_tail) tail_q <= 1'b1;

      if (phase_q == PH_IDLE)                   ptr_q <= '0;
      else if (enter_new && ptr_q != VEC_LAST)  ptr_q <= ptr_q + 1'b1;

      if (accept)                                          done_q <= 1'b0;
      else if (phase_q == PH_SHIFT && last_shift && tail_q) done_q <= 1'b1;
    end
  end

endmodule

// File: rtl/scanvec_lane.sv
module scanvec_lane #(
  parameter int SHIFT_LEN = 4,
  parameter int CW        = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 load_zero,
  input  logic                 advance,
  input  logic [SHIFT_LEN-1:0] bits,
  input  logic [CW-1:0]        cnt,
  input  logic                 cmp_en,
  input  logic [SHIFT_LEN-1:0] exp_bits,
  input  logic [SHIFT_LEN-1:0] care_bits,
  input  logic                 so_bit,
  output logic                 si_q,
  output logic                 miss
);

  logic [SHIFT_LEN-1:0] sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_q <= '0;
      si_q <= 1'b0;
    end else if (load) begin
      si_q <= bits[SHIFT_LEN-1];
      sh_q <= bits << 1;
    end else if (load_zero) begin
      si_q <= 1'b0;
      sh_q <= '0;
    end else if (advance) begin
      si_q <= sh_q[SHIFT_LEN-1];
      sh_q <= sh_q << 1;
    end else begin
      si_q <= 1'b0;
    end
  end

  assign miss = cmp_en && care_bits[cnt] && (so_bit != exp_bits[cnt]);

endmodule

// File: rtl/scanvec_verdict.sv
module scanvec_verdict #(
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          shift_miss,
  input  logic          po_miss,
  input  logic [IW-1:0] prev_idx,
  input  logic [IW-1:0] cur_idx,
  output logic          fail_q,
  output logic [IW-1:0] fail_idx_q
);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      fail_q     <= 1'b0;
      fail_idx_q <= '0;
    end else if (!fail_q) begin
      if (shift_miss) begin
        fail_q     <= 1'b1;
        fail_idx_q <= prev_idx;
      end else if (po_miss) begin
        fail_q     <= 1'b1;
        fail_idx_q <= cur_idx;
      end
    end
  end

endmodule

// File: rtl/scanvec_sequencer.sv
module scanvec_sequencer
  import scanvec_pkg::*;
#(
  parameter int NCHAIN    = 2,
  parameter int SHIFT_LEN = 4,
  parameter int NPI       = 3,
  parameter int NPO       = 2,
  parameter int NVEC      = 4,
  localparam int IW       = idx_bits(NVEC),
  localparam int LW       = NCHAIN * SHIFT_LEN,
  localparam int W        = NPI + 3 * LW + 2 * NPO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              wr_en,
  input  logic [IW-1:0]     wr_addr,
  input  logic [W-1:0]      wr_data,
  output logic              busy,
  output logic              done,
  output logic              fail,
  output logic [IW-1:0]     fail_vec,
  output logic              test_ctrl,
  output logic [NCHAIN-1:0] scan_in,
  input  logic [NCHAIN-1:0] scan_out,
  output logic [NPI-1:0]    pi_out,
  input  logic [NPO-1:0]    po_in
);

  localparam int CW      = idx_bits(SHIFT_LEN);
  localparam int LOAD_LO = 0;
  localparam int EXP_LO  = LW;
  localparam int CARE_LO = 2 * LW;
  localparam int PI_LO   = 3 * LW;
  localparam int EPO_LO  = PI_LO + NPI;
  localparam int MPO_LO  = EPO_LO + NPO;

  phase_e          phase_q, nxt_phase;
  logic [CW-1:0]   cnt_q;
  logic            first_q;
  logic [IW-1:0]   cur_idx_q, prev_idx_q, ptr_q;
  logic            enter_new, enter_tail, shift_more, accept;
  logic            busy_q, done_q, tc_q;
  logic [W-1:0]    rdata_q, cur_q;
  logic [LW-1:0]   prev_exp_q, prev_care_q;
  logic [NPI-1:0]  pi_q;
  logic [NCHAIN-1:0] si_vec, miss_vec;
  logic            we, cmp_en, shift_miss, po_miss;

  assign we = wr_en && (phase_q == PH_IDLE) && !start;

  scanvec_ctrl #(
    .SHIFT_LEN(SHIFT_LEN), .NVEC(NVEC), .CW(CW), .IW(IW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start),
    .phase_q(phase_q), .nxt_phase(nxt_phase), .cnt_q(cnt_q),
    .first_q(first_q), .cur_idx_q(cur_idx_q), .prev_idx_q(prev_idx_q),
    .ptr_q(ptr_q), .enter_new(enter_new), .enter_tail(enter_tail),
    .shift_more(shift_more), .accept(accept),
    .busy_q(busy_q), .done_q(done_q), .tc_q(tc_q)
  );

  scanvec_store #(.W(W), .DEPTH(NVEC), .AW(IW)) u_store (
    .clk(clk), .we(we), .waddr(wr_addr), .wdata(wr_data),
    .raddr(ptr_q), .rdata_q(rdata_q)
  );

  // vector under load/capture, and expectations of the one being unloaded
  always_ff @(posedge clk) begin
    if (rst) begin
      cur_q       <= '0;
      prev_exp_q  <= '0;
      prev_care_q <= '0;
      pi_q        <= '0;
    end else begin
      if (enter_new) cur_q <= rdata_q;
      if (phase_q == PH_CAPT) begin
        prev_exp_q  <= cur_q[EXP_LO +: LW];
        prev_care_q <= cur_q[CARE_LO +: LW];
      end
      pi_q <= (nxt_phase == PH_CAPT) ? cur_q[PI_LO +: NPI] : '0;
    end
  end

  assign cmp_en = (phase_q == PH_SHIFT) && !first_q;

  for (genvar c = 0; c < NCHAIN; c++) begin : g_lane
    scanvec_lane #(.SHIFT_LEN(SHIFT_LEN), .CW(CW)) u_lane (
      .clk(clk), .rst(rst),
      .load(enter_new), .load_zero(enter_tail), .advance(shift_more),
      .bits(rdata_q[LOAD_LO + c*SHIFT_LEN +: SHIFT_LEN]),
      .cnt(cnt_q), .cmp_en(cmp_en),
      .exp_bits(prev_exp_q[c*SHIFT_LEN +: SHIFT_LEN]),
      .care_bits(prev_care_q[c*SHIFT_LEN +: SHIFT_LEN]),
      .so_bit(scan_out[c]),
      .si_q(si_vec[c]), .miss(miss_vec[c])
    );
  end

  assign shift_miss = |miss_vec;
  assign po_miss    = (phase_q == PH_CAPT) &&
                      |((po_in ^ cur_q[EPO_LO +: NPO]) & cur_q[MPO_LO +: NPO]);

  scanvec_verdict #(.IW(IW)) u_verdict (
    .clk(clk), .rst(rst), .clear(accept),
    .shift_miss(shift_miss), .po_miss(po_miss),
    .prev_idx(prev_idx_q), .cur_idx(cur_idx_q),
    .fail_q(fail), .fail_idx_q(fail_vec)
  );

  assign busy      = busy_q;
  assign done      = done_q;
  assign test_ctrl = tc_q;
  assign scan_in   = si_vec;
  assign pi_out    = pi_q;

endmodule

// File: rtl/scanvec_sequencer_chk.sv
module scanvec_sequencer_chk #(
  parameter int NCHAIN = 2,
  parameter int NPI    = 3,
  parameter int IW     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              busy,
  input logic              done,
  input logic              fail,
  input logic [IW-1:0]     fail_vec,
  input logic              test_ctrl,
  input logic [NCHAIN-1:0] scan_in,
  input logic [NPI-1:0]    pi_out
);

  assert_idle_normal_R3: assert property (@(posedge clk) disable iff (rst)
    !busy |-> test_ctrl);

  assert_one_capture_R3: assert property (@(posedge clk) disable iff (rst)
    (busy && test_ctrl) |=> !test_ctrl);

  assert_pi_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    !(busy && test_ctrl) |-> (pi_out == '0));

  assert_si_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    test_ctrl |-> (scan_in == '0));

  assert_fail_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (fail && !(start && !busy)) |=> (fail && $stable(fail_vec)));

  assert_done_rest_R8: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

endmodule

bind scanvec_sequencer scanvec_sequencer_chk #(
  .NCHAIN(NCHAIN), .NPI(NPI), .IW(IW)
) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .fail(fail), .fail_vec(fail_vec), .test_ctrl(test_ctrl),
  .scan_in(scan_in), .pi_out(pi_out)
);

// File: tb/scanvec_sequencer_test.sv
module scanvec_sequencer_test;

  localparam int NVEC = 4;
  localparam int S    = 4;
  localparam int W    = 31;
  localparam int RUN_BUSY = 1 + (NVEC + 1) * S + NVEC;

  // stimulus table: {pi[2:0], load chain1[3:0], load chain0[3:0]}
  localparam logic [10:0] STIM [NVEC] = '{
    {3'b101, 4'hA, 4'h3},
    {3'b010, 4'h5, 4'hC},
    {3'b111, 4'hF, 4'h0},
    {3'b001, 4'h6, 4'h9}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [W-1:0] wr_data = '0;
  logic busy, done, fail, test_ctrl;
  logic [1:0] fail_vec;
  logic [1:0] scan_in, scan_out;
  logic [2:0] pi_out;
  logic [1:0] po_in;

  always #2 clk = ~clk;

  scanvec_sequencer uut (
    .clk(clk), .rst(rst), .start(start), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .busy(busy), .done(done), .fail(fail),
    .fail_vec(fail_vec), .test_ctrl(test_ctrl), .scan_in(scan_in),
    .scan_out(scan_out), .pi_out(pi_out), .po_in(po_in)
  );

  // circuit under test: chain0 = st[3:0] (4 cells), chain1 = st[5:4] (2 cells)
  function automatic logic [5:0] cut_next(input logic [5:0] s, input logic [2:0] p);
    return {s[4:0], s[5]} ^ {p, p};
  endfunction
  function automatic logic [1:0] cut_po(input logic [5:0] s, input logic [2:0] p);
    return {(^s) ^ p[1], s[0] & p[0]};
  endfunction

  logic [5:0] st = '0;
  assign scan_out = {st[4], st[0]};
  assign po_in    = cut_po(st, pi_out);
  always @(posedge clk) begin
    if (!test_ctrl) st <= {scan_in[1], st[5], scan_in[0], st[3:1]};
    else            st <= cut_next(st, pi_out);
  end

  function automatic logic [W-1:0] build(input logic [10:0] v);
    logic [3:0] l0, l1;
    logic [2:0] p;
    logic [5:0] s, n;
    l0 = v[3:0]; l1 = v[7:4]; p = v[10:8];
    s = {l1[0], l1[1], l0[0], l0[1], l0[2], l0[3]};
    n = cut_next(s, p);
    return {2'b11, cut_po(s, p), p, 8'b0011_1111, {2'b00, n[5:4], n[3:0]}, l1, l0};
  endfunction

  int errors = 0;
  int checks = 0;
  logic [W-1:0] gold [NVEC];

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // monitor, sampled away from the active edge
  int busy_cnt, shift_cnt, cap_cnt, pi_bad, si_bad;
  logic [2:0] cap_pi [8];
  logic [3:0] first0, first1;
  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (busy && !test_ctrl) begin
      if (shift_cnt < S) begin
        first0[S-1-shift_cnt] = scan_in[0];
        first1[S-1-shift_cnt] = scan_in[1];
      end
      shift_cnt++;
      if (cap_cnt == NVEC + 1 && scan_in != 2'b00) si_bad++;
    end
    if (busy && test_ctrl) begin
      if (cap_cnt < 8) cap_pi[cap_cnt] = pi_out;
      cap_cnt++;
    end else if (pi_out != 3'b000) pi_bad++;
    if (test_ctrl && scan_in != 2'b00) si_bad++;
  end

  task automatic wr(input int a, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_seq(input bit poke);
    @(negedge clk);
    busy_cnt = 0; shift_cnt = 0; cap_cnt = 0; pi_bad = 0; si_bad = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R8 done cleared by start", int'(done), 0);
    if (poke) begin
      repeat (6) @(negedge clk);
      start = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = ~gold[0];
      @(negedge clk);
      start = 1'b0; wr_en = 1'b0;
    end
    for (int t = 0; t < 200 && !done; t++) @(negedge clk);
    chk("R3 run reached done", int'(done), 1);
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 fail", int'(fail), 0);
    chk("R1 test_ctrl", int'(test_ctrl), 1);
    chk("R1 scan_in/pi", int'({scan_in, pi_out}), 0);

    for (int i = 0; i < NVEC; i++) begin
      gold[i] = build(STIM[i]);
      wr(i, gold[i]);
    end

    // clean run
    run_seq(1'b0);
    chk("R6 clean verdict", int'(fail), 0);
    chk("R3 busy length", busy_cnt, RUN_BUSY);
    chk("R3 shift cycles", shift_cnt, (NVEC + 1) * S);
    chk("R3 normal-mode cycles", cap_cnt, NVEC + 1);
    chk("R4 chain0 load order", int'(first0), int'(STIM[0][3:0]));
    chk("R4 chain1 load order", int'(first1), int'(STIM[0][7:4]));
    for (int k = 0; k < NVEC; k++)
      chk("R5 capture pi", int'(cap_pi[k + 1]), int'(STIM[k][10:8]));
    chk("R5 pi zero elsewhere", pi_bad, 0);
    chk("R5 scan_in quiet", si_bad, 0);

    // unload error in vector 2, chain1 bit0 (word bit 12)
    wr(2, gold[2] ^ (W'(1) << 12));
    run_seq(1'b0);
    chk("R6 R2 unload mismatch flagged", int'(fail), 1);
    chk("R6 failing index", int'(fail_vec), 2);

    // earlier primary-output error in vector 1 (word bit 27)
    wr(1, gold[1] ^ (W'(1) << 27));
    run_seq(1'b0);
    chk("R7 po mismatch flagged", int'(fail), 1);
    chk("R8 first failing index", int'(fail_vec), 1);

    // error under a cleared care bit: chain0 exp bit3 (11), care bit (19)
    wr(2, gold[2]);
    wr(1, (gold[1] ^ (W'(1) << 11)) & ~(W'(1) << 19));
    run_seq(1'b0);
    chk("R6 masked bit ignored", int'(fail), 0);

    // error only the final unload pass sees: vector 3 chain0 exp bit1
    wr(1, gold[1]);
    wr(3, gold[3] ^ (W'(1) << 9));
    run_seq(1'b0);
    chk("R6 tail unload mismatch", int'(fail), 1);
    chk("R6 tail failing index", int'(fail_vec), 3);

    // start and write while busy are ignored
    wr(3, gold[3]);
    run_seq(1'b1);
    chk("R3 start while busy ignored", busy_cnt, RUN_BUSY);
    chk("R8 fail cleared by start", int'(fail), 0);
    repeat (3) @(negedge clk);
    chk("R8 done held", int'(done), 1);
    run_seq(1'b0);
    chk("R2 write while busy ignored", int'(fail), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule